// File: doc/BRIEF.md
# Teletext Bit Request and Insertion Window Generator

This block paces the delivery of a teletext bitstream from an external source into a video encoder. On video lines that software has picked for text, it opens an insertion window at a set horizontal position. Inside the window it emits one single-cycle request pulse per text bit, paced by a phase accumulator so that the average rate matches the selected text standard. The window closes once the standard's bit count, run-in included, has been requested. The source answers each request with one bit. The block samples that bit a programmable number of clocks after the request and hands it to the downstream modulator with a one-cycle valid strobe.

Lines are picked with one 32-bit mask per field. Each mask covers 32 consecutive lines, starting at a programmable first line, so the two fields are configured independently. In an alternative mode the request pin stops carrying requests and outputs the block clock divided by two, which the text source can use as a clock.

Everything runs on the block clock, and the incoming bit is sampled on it.

Top module: `ttx_req_gen`

## Requirements
- R1: While reset is held and directly after it, `req_o`, `bit_vld_o` and `win_o` are low.
- R2: The line number and field are sampled in the cycle in which `line_start` is high. The line is selected when idx = `line_num` − `cfg_first_line` satisfies 0 ≤ idx ≤ 31 and bit idx of the field's mask is set. Field 0 uses `cfg_mask_f0` and field 1 uses `cfg_mask_f1`. No window opens on a line that is not selected.
- R3: On a selected line, `win_o` first goes high in cycle n+2+`cfg_hoffs`, where n is the cycle in which `line_start` was high.
- R4: Window cycles are numbered j = 0, 1, … from the first cycle in which `win_o` is high. A 16-bit accumulator starts at 0 and adds the mode's increment in every window cycle. The increments are 16839 for mode 0 and 13902 for modes 1 and 2. When floor((j+1)·inc/65536) > floor(j·inc/65536), `req_o` is high for exactly the one cycle that follows window cycle j.
- R5: `cfg_mode` is encoded as 0 = 625-line world system text, 1 = 525-line world system text, 2 = North American broadcast text, 3 = reserved. Each window issues exactly 360, 296 or 288 requests for modes 0, 1 and 2. `win_o` falls after the window cycle that produced the last request.
- R6: For a request during cycle T and delay d = `cfg_delay` (0 to 15), `ttx_in` is sampled at the clock edge that ends cycle T+d. The sampled value appears on `bit_o` with `bit_vld_o` high during cycle T+1+d only.
- R7: When `cfg_en` is low or `cfg_mode` is 3, no window opens and no requests are issued.
- R8: While `cfg_clk_out` is high, `req_o` inverts every cycle, which gives half the block clock rate. In that mode no window opens and `bit_vld_o` stays low.
- R9: A `line_start` during an open window closes the window. A wrap in that same cycle produces no request. Bits for requests issued earlier are still delivered as in R6.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock (crystal rate) |
| rst_n | input | 1 | Asynchronous active-low reset |
| line_start | input | 1 | One-cycle pulse at the start of each video line |
| field | input | 1 | Current field (0 or 1) |
| line_num | input | 10 | Current line number |
| cfg_en | input | 1 | Text insertion enable |
| cfg_clk_out | input | 1 | Request pin carries half-rate clock instead of requests |
| cfg_mode | input | 2 | Text standard select |
| cfg_first_line | input | 10 | Line number that mask bit 0 refers to |
| cfg_mask_f0 | input | 32 | Line-select mask for field 0 |
| cfg_mask_f1 | input | 32 | Line-select mask for field 1 |
| cfg_hoffs | input | 12 | Window start offset in clocks after the line start |
| cfg_delay | input | 4 | Clocks between a request and the sampling of its bit |
| ttx_in | input | 1 | Serial text bit from the source |
| req_o | output | 1 | Request pulses, or half-rate clock |
| bit_o | output | 1 | Captured text bit |
| bit_vld_o | output | 1 | One-cycle strobe for `bit_o` |
| win_o | output | 1 | Insertion window active |

## Verification
Two things can fall in the same cycle: the start of a new line and an accumulator wrap inside a still-open window. The bench provokes this by searching for a short line length whose last cycle is a wrap cycle, then starting the next selected line immediately. It expects the request from the last full cycle before the line start, no request in the cycle after it, and a fresh window at the normal offset. The bits already requested must still arrive with the configured delay, even though their delivery overlaps the start of the new line.

// File: rtl/ttx_pkg.sv
`timescale 1ns/1ps
package ttx_pkg;

  typedef enum logic [1:0] {
    TTX_625_WST = 2'd0,
    TTX_525_WST = 2'd1,
    TTX_NA_BCST = 2'd2,
    TTX_RSVD    = 2'd3
  } ttx_mode_e;

endpackage

// File: rtl/ttx_line_sel.sv
`timescale 1ns/1ps
module ttx_line_sel #(
  parameter int LINE_W = 10,
  parameter int MASK_N = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              line_start,
  input  logic              field,
  input  logic [LINE_W-1:0] line_num,
  input  logic [LINE_W-1:0] first_line,
  input  logic [MASK_N-1:0] mask_f0,
  input  logic [MASK_N-1:0] mask_f1,
  output logic              sel_q
);
  localparam int IDX_W = $clog2(MASK_N);

  logic [LINE_W-1:0] diff;
  logic              in_range;
  logic [IDX_W-1:0]  idx;
  logic              mask_bit;
  logic              sel_d;

  always_comb begin
    diff     = line_num - first_line;
    in_range = (line_num >= first_line) && (32'(diff) < MASK_N);
    idx      = diff[IDX_W-1:0];
    mask_bit = field ? mask_f1[idx] : mask_f0[idx];
    sel_d    = sel_q;
    if (line_start) sel_d = in_range && mask_bit;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sel_q <= 1'b0;
    else        sel_q <= sel_d;
  end

  // R2: selection only moves at a line start
  a_r2_sel_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !line_start |=> $stable(sel_q));

endmodule

// File: rtl/ttx_pacer.sv
`timescale 1ns/1ps
module ttx_pacer
  import ttx_pkg::*;
#(
  parameter int ACC_W    = 16,
  parameter int HCNT_W   = 12,
  parameter int INC_625  = 16839,
  parameter int INC_525  = 13902,
  parameter int INC_NA   = 13902,
  parameter int LEN_625  = 360,
  parameter int LEN_525  = 296,
  parameter int LEN_NA   = 288
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              line_start,
  input  logic              line_sel,
  input  logic              cfg_en,
  input  logic              cfg_clk_out,
  input  logic [1:0]        cfg_mode,
  input  logic [HCNT_W-1:0] cfg_hoffs,
  output logic              req_q,
  output logic              req_evt,
  output logic              win_q
);
  localparam int LEN_MAX = (LEN_625 > LEN_525) ?
                           ((LEN_625 > LEN_NA) ? LEN_625 : LEN_NA) :
                           ((LEN_525 > LEN_NA) ? LEN_525 : LEN_NA);
  localparam int CNT_W = $clog2(LEN_MAX + 1);
  localparam logic [HCNT_W-1:0] HC_MAX = '1;

  logic [HCNT_W-1:0] hcnt_q, hcnt_d;
  logic              armed_q, armed_d;
  logic              win_d;
  logic [ACC_W-1:0]  acc_q, acc_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic              req_d;
  logic              mode_clk_q;
  logic [ACC_W-1:0]  inc_sel;
  logic [CNT_W-1:0]  len_sel;
  logic              mode_ok;
  logic [ACC_W:0]    sum;
  logic              fire;
  logic              open_win;

  ttx_mode_e mode;
  assign mode = ttx_mode_e'(cfg_mode);

  always_comb begin
    mode_ok = 1'b1;
    case (mode)
      TTX_625_WST: begin inc_sel = ACC_W'(INC_625); len_sel = CNT_W'(LEN_625); end
      TTX_525_WST: begin inc_sel = ACC_W'(INC_525); len_sel = CNT_W'(LEN_525); end
      TTX_NA_BCST: begin inc_sel = ACC_W'(INC_NA);  len_sel = CNT_W'(LEN_NA);  end
      default: begin inc_sel = '0; len_sel = '0; mode_ok = 1'b0; end
    endcase
  end

  always_comb begin
    open_win = armed_q && !line_start && (hcnt_q == cfg_hoffs) && line_sel &&
               cfg_en && !cfg_clk_out && mode_ok;

    hcnt_d = hcnt_q;
    if (line_start)            hcnt_d = '0;
    else if (hcnt_q != HC_MAX) hcnt_d = hcnt_q + 1'b1;

    armed_d = armed_q;
    win_d   = win_q;
    acc_d   = acc_q;
    cnt_d   = cnt_q;
    fire    = 1'b0;
    sum     = {1'b0, acc_q} + {1'b0, inc_sel};

    if (win_q) begin
      acc_d = sum[ACC_W-1:0];
      if (sum[ACC_W]) begin
        fire  = 1'b1;
        cnt_d = cnt_q + 1'b1;
        if (CNT_W'(cnt_q + 1'b1) == len_sel) win_d = 1'b0;
      end
    end

    if (open_win) begin
      win_d   = 1'b1;
      acc_d   = '0;
      cnt_d   = '0;
      armed_d = 1'b0;
    end

    if (line_start) armed_d = 1'b1;

    if (line_start || !cfg_en || cfg_clk_out) begin
      win_d = 1'b0;
      fire  = 1'b0;
    end

    req_d = cfg_clk_out ? ~req_q : fire;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hcnt_q     <= '0;
      armed_q    <= 1'b0;
      win_q      <= 1'b0;
      acc_q      <= '0;
      cnt_q      <= '0;
      req_q      <= 1'b0;
      mode_clk_q <= 1'b0;
    end else begin
      hcnt_q     <= hcnt_d;
      armed_q    <= armed_d;
      win_q      <= win_d;
      acc_q      <= acc_d;
      cnt_q      <= cnt_d;
      req_q      <= req_d;
      mode_clk_q <= cfg_clk_out;
    end
  end

  assign req_evt = req_q && !mode_clk_q;

  // R4: requests are isolated single-cycle pulses
  a_r4_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    req_evt |=> !req_evt);
  // R5: the request count never reaches the limit inside an open window
  a_r5_cnt_limit: assert property (@(posedge clk) disable iff (!rst_n)
    win_q |-> (cnt_q < len_sel));
  // R3: a window only opens on a selected line
  a_r3_open_sel: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(win_q) |-> line_sel);
  // R7: disabling closes the window
  a_r7_off: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_en |=> !win_q);
  // R8: clock mode carries no window and no request
  a_r8_alt: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_clk_out |=> (!win_q && !req_evt));
  // R9: a line start inside the window swallows that cycle's wrap
  a_r9_abort: assert property (@(posedge clk) disable iff (!rst_n)
    (line_start && win_q) |=> !req_evt);

endmodule

// File: rtl/ttx_bit_capture.sv
`timescale 1ns/1ps
module ttx_bit_capture #(
  parameter int DLY_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_evt,
  input  logic [DLY_W-1:0] cfg_delay,
  input  logic             ttx_in,
  output logic             bit_q,
  output logic             vld_q
);
  localparam int DLY_MAX = (1 << DLY_W) - 1;

  logic [DLY_MAX-1:0] sr_q, sr_d;
  logic               tap;
  logic               bit_d;

  always_comb begin
    sr_d = {sr_q[DLY_MAX-2:0], req_evt};
    if (cfg_delay == '0) tap = req_evt;
    else                 tap = sr_q[cfg_delay - 1'b1];
    bit_d = tap ? ttx_in : bit_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr_q  <= '0;
      bit_q <= 1'b0;
      vld_q <= 1'b0;
    end else begin
      sr_q  <= sr_d;
      bit_q <= bit_d;
      vld_q <= tap;
    end
  end

  // R6: requests arrive at least three cycles apart, so the delay line is sparse
  a_r6_sparse: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({sr_q[1:0], req_evt}) <= 1);
  // R6: with a steady delay, strobes never come back to back
  a_r6_vld_iso: assert property (@(posedge clk) disable iff (!rst_n)
    vld_q ##1 $stable(cfg_delay) |-> !vld_q);

endmodule

// File: rtl/ttx_req_gen.sv
`timescale 1ns/1ps
module ttx_req_gen #(
  parameter int LINE_W  = 10,
  parameter int MASK_N  = 32,
  parameter int HCNT_W  = 12,
  parameter int DLY_W   = 4,
  parameter int ACC_W   = 16,
  parameter int INC_625 = 16839,
  parameter int INC_525 = 13902,
  parameter int INC_NA  = 13902,
  parameter int LEN_625 = 360,
  parameter int LEN_525 = 296,
  parameter int LEN_NA  = 288
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              line_start,
  input  logic              field,
  input  logic [LINE_W-1:0] line_num,
  input  logic              cfg_en,
  input  logic              cfg_clk_out,
  input  logic [1:0]        cfg_mode,
  input  logic [LINE_W-1:0] cfg_first_line,
  input  logic [MASK_N-1:0] cfg_mask_f0,
  input  logic [MASK_N-1:0] cfg_mask_f1,
  input  logic [HCNT_W-1:0] cfg_hoffs,
  input  logic [DLY_W-1:0]  cfg_delay,
  input  logic              ttx_in,
  output logic              req_o,
  output logic              bit_o,
  output logic              bit_vld_o,
  output logic              win_o
);
  logic rst_meta_q, rst_sync_q;
  logic sel_q;
  logic req_evt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_q <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_q <= rst_meta_q;
    end
  end

  ttx_line_sel #(.LINE_W(LINE_W), .MASK_N(MASK_N)) u_sel (
    .clk        (clk),
    .rst_n      (rst_sync_q),
    .line_start (line_start),
    .field      (field),
    .line_num   (line_num),
    .first_line (cfg_first_line),
    .mask_f0    (cfg_mask_f0),
    .mask_f1    (cfg_mask_f1),
    .sel_q      (sel_q)
  );

  ttx_pacer #(
    .ACC_W(ACC_W), .HCNT_W(HCNT_W),
    .INC_625(INC_625), .INC_525(INC_525), .INC_NA(INC_NA),
    .LEN_625(LEN_625), .LEN_525(LEN_525), .LEN_NA(LEN_NA)
  ) u_pace (
    .clk         (clk),
    .rst_n       (rst_sync_q),
    .line_start  (line_start),
    .line_sel    (sel_q),
    .cfg_en      (cfg_en),
    .cfg_clk_out (cfg_clk_out),
    .cfg_mode    (cfg_mode),
    .cfg_hoffs   (cfg_hoffs),
    .req_q       (req_o),
    .req_evt     (req_evt),
    .win_q       (win_o)
  );

  ttx_bit_capture #(.DLY_W(DLY_W)) u_cap (
    .clk       (clk),
    .rst_n     (rst_sync_q),
    .req_evt   (req_evt),
    .cfg_delay (cfg_delay),
    .ttx_in    (ttx_in),
    .bit_q     (bit_o),
    .vld_q     (bit_vld_o)
  );

  // R1: outputs stay quiet while the synchronised reset is held
  a_r1_reset_quiet: assert property (@(posedge clk)
    !rst_sync_q |=> (!win_o && !bit_vld_o));

endmodule

// File: tb/sim_ttx_req_gen.sv
`timescale 1ns/1ps
module sim_ttx_req_gen;

  typedef struct {
    int     n;
    bit     sel;
    longint inc;
    int     len;
    int     hoffs;
  } line_t;

  localparam int HN = 4096;
  localparam int BIG = 32'h7fffffff;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        line_start = 1'b0;
  logic        field = 1'b0;
  logic [9:0]  line_num = '0;
  logic        cfg_en = 1'b1;
  logic        cfg_clk_out = 1'b0;
  logic [1:0]  cfg_mode = 2'd0;
  logic [9:0]  cfg_first_line = 10'd40;
  logic [31:0] cfg_mask_f0 = 32'h8000_0005;
  logic [31:0] cfg_mask_f1 = 32'h0000_4002;
  logic [11:0] cfg_hoffs = 12'd10;
  logic [3:0]  cfg_delay = 4'd0;
  logic        ttx_in = 1'b0;
  logic        req_o, bit_o, bit_vld_o, win_o;

  int  cyc = 0;
  int  total = 0;
  int  bad = 0;
  bit  mon_on = 0;
  bit  clk_prev = 0;
  bit  finished = 0;
  bit  hist_r [HN];
  bit  hist_w [HN];
  line_t prev_l;

  always #4 clk = ~clk;

  ttx_req_gen u0 (
    .clk(clk), .rst_n(rst_n), .line_start(line_start), .field(field),
    .line_num(line_num), .cfg_en(cfg_en), .cfg_clk_out(cfg_clk_out),
    .cfg_mode(cfg_mode), .cfg_first_line(cfg_first_line),
    .cfg_mask_f0(cfg_mask_f0), .cfg_mask_f1(cfg_mask_f1),
    .cfg_hoffs(cfg_hoffs), .cfg_delay(cfg_delay), .ttx_in(ttx_in),
    .req_o(req_o), .bit_o(bit_o), .bit_vld_o(bit_vld_o), .win_o(win_o)
  );

  function automatic logic pat(input int c);
    return logic'(((c * 13) ^ (c >> 2) ^ (c >> 5)) & 1);
  endfunction

  function automatic longint inc_of(input int m);
    return (m == 0) ? 64'd16839 : 64'd13902;
  endfunction

  function automatic int len_of(input int m);
    return (m == 0) ? 360 : (m == 1) ? 296 : 288;
  endfunction

  function automatic bit wraps(input longint inc, input longint j);
    return (((j + 1) * inc) >> 16) != ((j * inc) >> 16);
  endfunction

  function automatic int jlast(input line_t r);
    return int'(((longint'(r.len) * 65536) + r.inc - 1) / r.inc) - 1;
  endfunction

  function automatic bit m_req(input line_t r, input int c, input int cut);
    longint j;
    if (!r.sel || c > cut) return 1'b0;
    j = c - (r.n + 3 + r.hoffs);
    if (j < 0) return 1'b0;
    return wraps(r.inc, j) && ((((j + 1) * r.inc) >> 16) <= r.len);
  endfunction

  function automatic bit m_win(input line_t r, input int c, input int cut);
    int w;
    if (!r.sel || c > cut) return 1'b0;
    w = c - (r.n + 2 + r.hoffs);
    return (w >= 0) && (w <= jlast(r));
  endfunction

  // cycle counter and source bit stream
  always @(posedge clk) begin
    cyc = cyc + 1;
    #2 ttx_in = pat(cyc);
  end

  // monitor: history of requests and window, full check of the capture path (R6)
  always @(negedge clk) begin
    int c0;
    bit ev;
    if (mon_on) begin
      hist_r[cyc % HN] = req_o && !clk_prev;
      hist_w[cyc % HN] = win_o;
      c0 = cyc - 1 - int'(cfg_delay);
      ev = (c0 >= 0) ? hist_r[c0 % HN] : 1'b0;
      if (ev || bit_vld_o) begin
        total++;
        if (bit_vld_o !== ev || (ev && bit_o !== pat(cyc - 1))) begin
          bad++;
          $display("FAIL R6 cyc=%0d actual vld=%0b bit=%0b expected vld=%0b bit=%0b",
                   cyc, bit_vld_o, bit_o, ev, pat(cyc - 1));
        end
      end
      clk_prev = cfg_clk_out;
    end
  end

  task automatic tick();
    @(posedge clk);
    #2;
  endtask

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic run_line(input int lcyc, input int ln, input bit fld, input string tag);
    line_t cur;
    int idx, nreq, ereq, rbad, wbad, nwin, ewin;
    bit er, ew;
    tick();
    line_start = 1'b1;
    line_num   = ln[9:0];
    field      = fld;
    cur.n      = cyc;
    cur.hoffs  = int'(cfg_hoffs);
    cur.inc    = inc_of(int'(cfg_mode));
    cur.len    = len_of(int'(cfg_mode));
    idx        = ln - int'(cfg_first_line);
    cur.sel    = cfg_en && (cfg_mode != 2'd3) && !cfg_clk_out && idx >= 0 && idx < 32 &&
                 (fld ? cfg_mask_f1[idx % 32] : cfg_mask_f0[idx % 32]);
    repeat (lcyc - 1) begin
      tick();
      line_start = 1'b0;
    end
    @(negedge clk);
    #1;
    nreq = 0; ereq = 0; rbad = 0; wbad = 0; nwin = 0; ewin = 0;
    for (int c = cur.n; c < cur.n + lcyc; c++) begin
      er = m_req(cur, c, BIG) || (c == cur.n && m_req(prev_l, c, cur.n));
      ew = m_win(cur, c, BIG) || (c == cur.n && m_win(prev_l, c, cur.n));
      nreq += int'(hist_r[c % HN]);
      ereq += int'(er);
      nwin += int'(hist_w[c % HN]);
      ewin += int'(ew);
      if (hist_r[c % HN] != er) rbad++;
      if (hist_w[c % HN] != ew) wbad++;
    end
    check(nreq == ereq, {tag, " R5 request count"}, nreq, ereq);
    check(rbad == 0,    {tag, " R4 request timing mismatches"}, rbad, 0);
    check(wbad == 0 && nwin == ewin, {tag, " R3 window cycles"}, nwin, ewin);
    prev_l = cur;
  endtask

  // watchdog
  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog all-R actual=running expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int la, j, toggles, quiet;
    bit lastr;
    for (int i = 0; i < HN; i++) begin
      hist_r[i] = 1'b0;
      hist_w[i] = 1'b0;
    end
    prev_l = '{n: 0, sel: 1'b0, inc: 64'd1, len: 0, hoffs: 0};

    // R1: reset state
    repeat (3) tick();
    @(negedge clk);
    check(req_o == 1'b0 && win_o == 1'b0 && bit_vld_o == 1'b0, "R1 outputs in reset",
          {req_o, win_o, bit_vld_o}, 0);
    tick();
    rst_n = 1'b1;
    repeat (4) tick();
    @(negedge clk);
    check(req_o == 1'b0 && win_o == 1'b0 && bit_vld_o == 1'b0, "R1 outputs after reset",
          {req_o, win_o, bit_vld_o}, 0);
    mon_on = 1'b1;
    repeat (20) tick();

    // R4 R5 R6: modes x delays, selected line 40 (field 0, idx 0)
    for (int m = 0; m < 3; m++) begin
      for (int d = 0; d < 16; d += 3) begin
        cfg_mode  = 2'(m);
        cfg_delay = 4'(d);
        cfg_hoffs = 12'(5 + m * 37 + d);
        repeat (20) tick();
        run_line(1600, 40, 1'b0, $sformatf("mode%0d d%0d", m, d));
      end
    end

    // R2: sweep lines around the mask span in both fields
    cfg_mode  = 2'd0;
    cfg_delay = 4'd4;
    cfg_hoffs = 12'd10;
    repeat (20) tick();
    for (int f = 0; f < 2; f++) begin
      for (int ln = 38; ln < 74; ln++) begin
        int ix;
        bit s;
        ix = ln - 40;
        s  = (ix >= 0 && ix < 32) && (f == 1 ? cfg_mask_f1[ix % 32] : cfg_mask_f0[ix % 32]);
        run_line(s ? 1600 : 60, ln, 1'(f), $sformatf("R2 line%0d f%0d sel%0b", ln, f, s));
      end
    end

    // R7: disabled, then reserved mode
    cfg_en = 1'b0;
    run_line(300, 40, 1'b0, "R7 disabled");
    cfg_en   = 1'b1;
    cfg_mode = 2'd3;
    run_line(300, 40, 1'b0, "R7 reserved mode");
    cfg_mode = 2'd0;
    repeat (20) tick();

    // R8: half-rate clock on the request pin
    cfg_clk_out = 1'b1;
    repeat (3) tick();
    @(negedge clk);
    lastr = req_o;
    toggles = 0;
    quiet = 0;
    for (int k = 0; k < 60; k++) begin
      tick();
      line_start = (k == 5);
      line_num   = 10'd40;
      field      = 1'b0;
      @(negedge clk);
      if (req_o != lastr) toggles++;
      if (win_o || bit_vld_o) quiet++;
      lastr = req_o;
    end
    line_start = 1'b0;
    check(toggles == 60, "R8 request pin toggles", toggles, 60);
    check(quiet == 0, "R8 no window or strobe", quiet, 0);
    tick();
    cfg_clk_out = 1'b0;
    repeat (20) tick();
    prev_l.sel = 1'b0;

    // R9: new line start falls on a wrap cycle inside an open window
    cfg_delay = 4'd9;
    cfg_hoffs = 12'd10;
    la = 600;
    for (int t = 600; t < 700; t++) begin
      j = t - 2 - 10;
      if (wraps(64'd16839, longint'(j))) begin
        la = t;
        break;
      end
    end
    repeat (20) tick();
    run_line(la, 40, 1'b0, "R9 cut line");
    run_line(1600, 40, 1'b0, "R9 following line");

    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule